// File: doc/BRIEF.md
# Delta-Update Addressable Register Array

This block is a small array of signed storage cells. Each cell holds its value in an accumulator that adds back onto itself every cycle. A write does not overwrite the cell. It adds a single correction, the new value minus the stored value, so the cell goes from the old value to the new one in one step and never shows a partial sum.

Every row carries a negative local address. A chain of decrementers builds these addresses: row 0 holds -1, and each later row holds one less than the row before it. A cell is picked when the incoming positive address plus its local address is zero. This rule applies to both the write port and the read port. Read requests and read data travel on separate buses, so the data bus carries only stored values.

A user sends a one-cycle write strobe with an address and data. At any time, a read address can be placed on the read port, and the matching cell's value appears on a registered output bus.

Top module: `delta_regarray`

## Requirements
- R1: While reset is high, every cell clears to 0 and rd_data clears to 0.
- R2: Address value k from 1 to N (N defaults to 8) selects row k-1, whose local address is -k. For example, address 8 selects the last row.
- R3: A single write stores exactly the written value, over the full signed range. A later read returns that value with no leftover from the previous contents.
- R4: A read address sampled at clock edge m shows its result on rd_data right after edge m+1.
- R5: A read sampled at the same edge as a write to the same cell returns the old value. A read sampled one or more edges later returns the new value.
- R6: rd_data is 0 when the read address is 0 or greater than N.
- R7: Two writes to the same cell land correctly when an idle cycle separates them. Writes to different cells on consecutive cycles both land.
- R8: If the strobe stays high on the same cell for two consecutive edges with data a then b, and the cell held c before, the cell ends at a+b-c (modulo 2^16). This is the defined result of breaking the one-cycle-strobe rule.
- R9: A write with address 0 or greater than N changes no cell.
- R10: Without a write, every cell keeps its value across any number of cycles and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Positive write address (1..N) |
| wr_data | input | DATA_W | Signed write value |
| rd_addr | input | ADDR_W | Positive read address (1..N, 0 = none) |
| rd_data | output | DATA_W | Registered value of the addressed cell, 0 when none |

## Verification
The write path is tested in several ways:
- writes into a cleared cell;
- writes over a non-zero value;
- writes at both ends of the signed range, where the correction value wraps;
- back-to-back writes to different rows.

These cases separate a true replace from an add. Reads placed at the same edge as a write, and one edge after it, test the pipeline timing between the two ports. A strobe held high on a cleared cell and on a loaded cell gives two different a+b-c results, which confirms that the correction is computed from the stale stored value. Addresses 0 and above N are sent on both ports to confirm that no row is selected.

// File: rtl/delta_regarray_pkg.sv
package delta_regarray_pkg;
  // Extra bits on local addresses so that -N and the sum with a positive address never wrap
  localparam int unsigned LOC_EXTRA = 2;

  function automatic int unsigned loc_width(input int unsigned addr_w);
    return addr_w + LOC_EXTRA;
  endfunction
endpackage

// File: rtl/delta_addr_chain.sv
module delta_addr_chain #(
  parameter int unsigned N    = 8,
  parameter int unsigned LA_W = 6
) (
  output logic [N-1:0][LA_W-1:0] loc
);
  // Row 0 starts at -1; each row subtracts one from its predecessor
  for (genvar i = 0; i < N; i++) begin : g_row
    if (i == 0) begin : g_head
      assign loc[i] = {LA_W{1'b1}};
    end else begin : g_link
      assign loc[i] = loc[i-1] - LA_W'(1);
    end
  end
endmodule

// File: rtl/delta_cell.sv
module delta_cell #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LA_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LA_W-1:0]          loc,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [DATA_W-1:0] val,
  output logic                     wr_hit,
  output logic                     rd_sel
);
  localparam int unsigned PAD = LA_W - ADDR_W;

  logic [LA_W-1:0]          wr_sum, rd_sum;
  logic                     pend_q;
  logic signed [DATA_W-1:0] delta_q;

  // Zero-sum match of positive request against negative local address
  assign wr_sum = {{PAD{1'b0}}, wr_addr} + loc;
  assign rd_sum = {{PAD{1'b0}}, rd_addr} + loc;
  assign wr_hit = wr_en && (wr_sum == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      delta_q <= '0;
      val     <= '0;
      rd_sel  <= 1'b0;
    end else begin
      pend_q  <= wr_hit;
      delta_q <= wr_data - val;            // new plus negated old
      val     <= val + (pend_q ? delta_q : '0);
      rd_sel  <= (rd_sum == '0);
    end
  end
endmodule

// File: rtl/delta_read_mux.sv
module delta_read_mux #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic [N-1:0][DATA_W-1:0] vals,
  input  logic [N-1:0]             sel,
  output logic [DATA_W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) dout = dout | vals[i];
    end
  end
endmodule

// File: rtl/delta_regarray.sv
module delta_regarray
  import delta_regarray_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic signed [DATA_W-1:0] rd_data
);
  localparam int unsigned LA_W = loc_width(ADDR_W);

  logic [N-1:0][LA_W-1:0]   loc;
  logic [N-1:0][DATA_W-1:0] vals;
  logic [N-1:0]             wr_hits;
  logic [N-1:0]             rd_sels;
  logic [DATA_W-1:0]        mux_out;

  delta_addr_chain #(.N(N), .LA_W(LA_W)) u_chain (.loc(loc));

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic signed [DATA_W-1:0] v;
    delta_cell #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LA_W(LA_W)) u_cell (
      .clk(clk), .rst(rst), .loc(loc[i]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .val(v), .wr_hit(wr_hits[i]), .rd_sel(rd_sels[i])
    );
    assign vals[i] = v;
  end

  delta_read_mux #(.N(N), .DATA_W(DATA_W)) u_mux (
    .vals(vals), .sel(rd_sels), .dout(mux_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux_out;
  end
endmodule

// File: rtl/delta_regarray_chk.sv
module delta_regarray_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic signed [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0]        rd_addr,
  input logic signed [DATA_W-1:0] rd_data,
  input logic [N-1:0]             wr_hits
);
  logic [2:0] up_cnt;
  always_ff @(posedge clk) begin
    if (rst) up_cnt <= '0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (rd_data == '0));

  // R6
  no_match_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((up_cnt >= 3'd2) && (($past(rd_addr, 2) == '0) || ($past(rd_addr, 2) > ADDR_W'(N))))
    |-> (rd_data == '0));

  // R2
  one_row_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr >= ADDR_W'(1)) && (wr_addr <= ADDR_W'(N))) |-> $onehot(wr_hits));

  // R9
  no_row_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (wr_addr == '0) || (wr_addr > ADDR_W'(N))) |-> (wr_hits == '0));

  // R3 R4 R5
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    ((up_cnt >= 3'd5) && $past(wr_en, 3) && ($past(wr_addr, 3) != '0)
      && ($past(wr_addr, 3) <= ADDR_W'(N))
      && ($past(rd_addr, 2) == $past(wr_addr, 3))
      && !($past(wr_en, 4) && ($past(wr_addr, 4) == $past(wr_addr, 3))))
    |-> (rd_data == $past(wr_data, 3)));
endmodule

bind delta_regarray delta_regarray_chk #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .wr_hits(wr_hits)
);

// File: tb/delta_regarray_test.sv
module delta_regarray_test;
  localparam int unsigned N = 8, DW = 16, AW = 4;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic signed [DW-1:0] wr_data = '0, rd_data;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  delta_regarray #(.N(N), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Each row is driven for one edge; exp is rd_data after that edge,
  // i.e. the result of the previous row's read address.
  typedef struct packed {
    logic          we;
    logic [3:0]    wa;
    logic [15:0]   wd;
    logic [3:0]    ra;
    logic [15:0]   exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd1, 16'd100,    4'd1, 16'd0,     4'd1},  // R1 idle read
    '{1'b0, 4'd0, 16'd0,      4'd1, 16'd0,     4'd5},  // R5 same-edge read: old
    '{1'b0, 4'd0, 16'd0,      4'd2, 16'd100,   4'd5},  // R5 R4 next edge: new
    '{1'b1, 4'd8, -16'sd5,    4'd8, 16'd0,     4'd1},  // R1 unwritten row
    '{1'b0, 4'd0, 16'd0,      4'd8, 16'd0,     4'd5},
    '{1'b0, 4'd0, 16'd0,      4'd0, -16'sd5,   4'd2},  // R2 address 8 = last row
    '{1'b1, 4'd0, 16'd77,     4'd9, 16'd0,     4'd6},  // R6 address 0
    '{1'b1, 4'd9, 16'd55,     4'd0, 16'd0,     4'd6},  // R6 address 9
    '{1'b0, 4'd0, 16'd0,      4'd1, 16'd0,     4'd6},
    '{1'b0, 4'd0, 16'd0,      4'd8, 16'd100,   4'd9},  // R9 row 0 untouched
    '{1'b1, 4'd3, 16'd1000,   4'd3, -16'sd5,   4'd9},  // R9 last row untouched
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'd0,     4'd5},
    '{1'b1, 4'd3, -16'sd2000, 4'd3, 16'd0,     4'd7},
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'd1000,  4'd7},  // R7 first of spaced pair
    '{1'b0, 4'd0, 16'd0,      4'd3, 16'd0,     4'd7},
    '{1'b0, 4'd0, 16'd0,      4'd0, -16'sd2000,4'd7},  // R7 second of spaced pair
    '{1'b1, 4'd4, 16'd11,     4'd0, 16'd0,     4'd7},
    '{1'b1, 4'd5, 16'd22,     4'd0, 16'd0,     4'd7},
    '{1'b0, 4'd0, 16'd0,      4'd4, 16'd0,     4'd7},
    '{1'b0, 4'd0, 16'd0,      4'd5, 16'd11,    4'd7},  // R7 consecutive rows
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'd22,    4'd7},
    '{1'b1, 4'd6, 16'd300,    4'd0, 16'd0,     4'd8},
    '{1'b1, 4'd6, 16'd400,    4'd0, 16'd0,     4'd8},
    '{1'b0, 4'd0, 16'd0,      4'd6, 16'd0,     4'd8},
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'd700,   4'd8},  // R8 300+400-0
    '{1'b1, 4'd1, 16'd10,     4'd0, 16'd0,     4'd8},
    '{1'b1, 4'd1, 16'd20,     4'd0, 16'd0,     4'd8},
    '{1'b0, 4'd0, 16'd0,      4'd1, 16'd0,     4'd8},
    '{1'b0, 4'd0, 16'd0,      4'd0, -16'sd70,  4'd8},  // R8 10+20-100
    '{1'b1, 4'd2, 16'h8000,   4'd0, 16'd0,     4'd3},
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'd0,     4'd3},
    '{1'b1, 4'd2, 16'h7fff,   4'd2, 16'd0,     4'd3},
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'h8000,  4'd3},  // R3 most negative
    '{1'b0, 4'd0, 16'd0,      4'd2, 16'd0,     4'd3},
    '{1'b0, 4'd0, 16'd0,      4'd0, 16'h7fff,  4'd3}   // R3 wrap of correction
  };

  task automatic drive(input logic we, input logic [AW-1:0] wa,
                       input logic [DW-1:0] wd, input logic [AW-1:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [DW-1:0] exp, input int req);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL R%0d: rd_data=%0d expected=%0d", req, rd_data, $signed(exp));
    end
  endtask

  // Final contents after the table; R10 holds them through idle cycles
  localparam logic [DW-1:0] FINAL [N] = '{-16'sd70, 16'h7fff, -16'sd2000,
                                          16'd11, 16'd22, 16'd700, 16'd0, -16'sd5};

  initial begin
    repeat (3) @(posedge clk);
    #1 check('0, 1);                        // R1 reset state
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].ra);
      check(VECS[i].exp, int'(VECS[i].req));
    end
    repeat (20) drive(1'b0, '0, '0, '0);  // R10 idle stretch
    for (int a = 1; a <= int'(N); a++) begin
      drive(1'b0, '0, '0, AW'(a));
      drive(1'b0, '0, '0, '0);
      check(FINAL[a-1], 10);                // R10 value held
    end
    // R1 reset mid-run clears every cell
    @(negedge clk) rst = 1'b1;
    @(posedge clk) #1 check('0, 1);
    @(negedge clk) rst = 1'b0;
    for (int a = 1; a <= int'(N); a++) begin
      drive(1'b0, '0, '0, AW'(a));
      drive(1'b0, '0, '0, '0);
      check('0, 1);                         // R1 cell cleared
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule